// File: doc/BRIEF.md
# Multi-Lane Serial Memory Host Controller

This block is a register-mapped host for serial peripherals such as flash memories. Software writes 32-bit registers to set the clock polarity and phase, the clock divider, the chip-select mode and the lane width of the next operation. It then starts a transfer by writing a word to one of four transmit addresses. The address chosen sets how many bytes of the word, from one to four, go out on the wire. The controller clocks those bytes out on one, two or four data lanes and collects the bytes the peripheral returns. When the transfer ends it places them in a single receive holding register that is read through the same register port.

A command sequence for a memory has a command phase, an address phase, a dummy phase and a data phase. Software builds it from a series of these transfers while the chip select is held low by hand. Dummy cycles are sent as all-ones bytes. A read-only data phase sets a read flag in the operation word. With the flag set, the host no longer drives the data lanes: on one lane it holds the output line high, and on two or four lanes it releases every data lane so the peripheral can drive it.

Top module: `spi_lane_host`

Register offsets: config 0x00, status 0x04, enable 0x10, transmit 0x14/0x18/0x1C/0x20, receive 0x24, divider 0x28, operation word 0x30.

## Requirements
- R1: After reset the status register at 0x04 reads 0x0000000B. Its bits are: bit 0 transmit empty, bit 1 transmit not full, bit 2 receive word pending, bit 3 receive not full, bit 4 sticky overflow.
- R2: A write to 0x14 + 4k starts a transfer of k bytes, with k = 0 meaning 4 bytes. The write is ignored while the enable register (0x10 bit 0) is clear or while a transfer is running (status bit 0 low).
- R3: On one lane, bytes leave starting from bits 7:0 of the written word, each byte most significant bit first, on sioOut[0]. Incoming bits are taken from sioIn[1].
- R4: Each transfer of n bytes yields one receive word at 0x24. Received byte i (0 = first) sits at bits 8(4-n+i)+7 : 8(4-n+i), and the bits below are zero.
- R5: Reading 0x24 removes the pending word: status bit 2 clears and bit 3 sets.
- R6: If a transfer completes while the previous word is unread, the new word replaces the old one and status bit 4 sets and stays set. Writing a 1 to bit 4 of 0x04 clears it.
- R7: Bits 7:6 of the operation word at 0x30 select the lane count: 0 = one, 1 = two, 2 = four, 3 = four. On two or four lanes each clock carries the next 2 or 4 bits of the byte, most significant first, with the higher lane carrying the higher bit.
- R8: Bit 23 of the operation word marks a read. On one lane sioOut[0] is held at 1 for the whole transfer. A two-lane read drives sioOe = 4'b1100 and a four-lane read drives sioOe = 4'b0000.
- R9: sclk rests at config bit 19 when no transfer runs. Each half period lasts N+1 system clocks, where N is the value at 0x28. A transfer of n bytes on L lanes produces 16n/L clock edges.
- R10: With config bit 20 = 0 the input is sampled on the leading edge and the output changes on the trailing edge. With bit 20 = 1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R11: With config bit 1 set, csN is low exactly when config bit 0 and the enable bit are both 1. With bit 1 clear, csN is low only while a transfer runs.
- R12: While enabled and idle, sioOe = 4'b1101 and the driven lanes sit at the level of config bit 16. While the enable bit is clear, sioOe = 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the receive word at 0x24) |
| regAddr | input | ADDR_W | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| sioOut | output | 4 | Data lane output values |
| sioOe | output | 4 | Data lane output enables |
| sioIn | input | 4 | Data lane input values |

## Verification
Most internal faults surface at the wire within a single transfer. A wrong edge counter shows up as an extra or missing sclk edge before the done flag rises. A wrong lane selection or read-flag decode corrupts the output enables or the first bits captured, within the first clock period. Faults in alignment, byte order and the receive holding logic stay hidden on the wire. They appear at the next read of 0x24 or 0x04, where the returned word or the pending and overflow bits differ from the value computed for the bytes the peripheral model sent.

// File: rtl/spi_lane_host_pkg.sv
package spi_lane_host_pkg;

  localparam int OFF_CFG = 'h00;
  localparam int OFF_STS = 'h04;
  localparam int OFF_EN  = 'h10;
  localparam int OFF_TXD = 'h14;
  localparam int OFF_RXD = 'h24;
  localparam int OFF_DIV = 'h28;
  localparam int OFF_OPC = 'h30;

  localparam int WORD_BYTES = 4;
  localparam int MAX_EDGES  = WORD_BYTES * 8 * 2;
  localparam int EDGE_W     = $clog2(MAX_EDGES) + 1;

  localparam int CFG_CS_ASSERT = 0;
  localparam int CFG_CS_MANUAL = 1;
  localparam int CFG_IDLE_LVL  = 16;
  localparam int CFG_CPOL      = 19;
  localparam int CFG_CPHA      = 20;
  localparam int OPC_READ      = 23;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xferState_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
    logic pop;
    logic clrOvf;
  } dpStrobe_t;

  typedef struct packed {
    logic [1:0] laneSel;
    logic       rdMode;
    logic [2:0] nBytes;
  } xferDesc_t;

  function automatic logic [1:0] laneSelFromCode(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/spi_lane_ctrl.sv
module spi_lane_ctrl
  import spi_lane_host_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       cfgReg,
  output logic              hostEn,
  output logic [DIV_W-1:0]  divReg,
  output logic [31:0]       opReg,
  output xferDesc_t         desc,
  output dpStrobe_t         strb,
  output logic              busy,
  output logic              sclk,
  output logic              csN
);

  localparam int IDX_W = ADDR_W - 2;

  xferState_e        state;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeTotal;
  logic [EDGE_W-1:0] lastEdge;
  logic [IDX_W-1:0]  txIdx;
  logic              txHit;
  logic              txAccept;
  logic              edgeNow;
  logic [2:0]        newBytes;
  logic              cpol;
  logic              cpha;

  assign cpol = cfgReg[CFG_CPOL];
  assign cpha = cfgReg[CFG_CPHA];

  // Transmit address decode: index 0..3 from 0x14..0x20
  assign txIdx    = regAddr[ADDR_W-1:2] - IDX_W'(OFF_TXD >> 2);
  assign txHit    = regWrEn && (regAddr[1:0] == 2'b00) && (txIdx < IDX_W'(4));
  assign txAccept = txHit && hostEn && (state == ST_IDLE);
  assign newBytes = (txIdx[1:0] == 2'd0) ? 3'd4 : {1'b0, txIdx[1:0]};

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      hostEn <= 1'b0;
      divReg <= '0;
      opReg  <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(OFF_CFG)) cfgReg <= regWdata;
      if (regAddr == ADDR_W'(OFF_EN))  hostEn <= regWdata[0];
      if (regAddr == ADDR_W'(OFF_DIV)) divReg <= regWdata[DIV_W-1:0];
      if (regAddr == ADDR_W'(OFF_OPC)) opReg  <= regWdata;
    end
  end

  // Edge budget of the running transfer
  assign edgeTotal = (EDGE_W'(desc.nBytes) << 4) >> desc.laneSel;
  assign lastEdge  = edgeTotal - EDGE_W'(1);
  assign edgeNow   = (state == ST_RUN) && (divCnt == divReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      sclk    <= 1'b0;
      desc    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclk <= cpol;
          if (txAccept) begin
            state   <= ST_RUN;
            divCnt  <= '0;
            edgeCnt <= '0;
            desc    <= '{laneSel: laneSelFromCode(opReg[7:6]),
                         rdMode:  opReg[OPC_READ],
                         nBytes:  newBytes};
          end
        end
        ST_RUN: begin
          if (edgeNow) begin
            divCnt  <= '0;
            sclk    <= ~sclk;
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (edgeCnt == lastEdge) state <= ST_FIN;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobes to the datapath
  always_comb begin
    strb        = '0;
    strb.load   = txAccept;
    strb.sample = edgeNow && (edgeCnt[0] == cpha);
    strb.shift  = edgeNow && (edgeCnt[0] != cpha) && (edgeCnt != '0);
    strb.finish = (state == ST_FIN);
    strb.pop    = regRdEn && (regAddr == ADDR_W'(OFF_RXD));
    strb.clrOvf = regWrEn && (regAddr == ADDR_W'(OFF_STS)) && regWdata[4];
  end

  assign busy = (state != ST_IDLE);
  assign csN  = ~(hostEn & (cfgReg[CFG_CS_MANUAL] ? cfgReg[CFG_CS_ASSERT] : busy));

  AST_TX_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txHit) |=> $stable(desc)); // R2
  AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> (sclk == $past(cpol))); // R9
  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (edgeCnt <= lastEdge)); // R9
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift, strb.sample, strb.finish})); // R10
  AST_FIN_REST_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |-> (sclk == $past(sclk, 1) || edgeCnt[0] == 1'b0)); // R9

endmodule

// File: rtl/spi_lane_dp.sv
module spi_lane_dp
  import spi_lane_host_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  xferDesc_t   desc,
  input  logic [31:0] loadWord,
  input  logic        hostEn,
  input  logic        idleLvl,
  input  logic        busy,
  input  logic [3:0]  sioIn,
  output logic [3:0]  sioOut,
  output logic [3:0]  sioOe,
  output logic [31:0] rxWord,
  output logic        rxValid,
  output logic        rxOvf
);

  logic [31:0] txShift;
  logic [31:0] rxBits;
  logic [31:0] alignWord;
  logic [31:0] swapWord;

  // First byte on the wire goes to the top of the shifter
  always_comb begin
    for (int b = 0; b < WORD_BYTES; b++) begin
      swapWord[8*(WORD_BYTES-1-b) +: 8] = loadWord[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxBits  <= '0;
    end else if (strb.load) begin
      txShift <= swapWord;
      rxBits  <= '0;
    end else begin
      if (strb.shift) begin
        case (desc.laneSel)
          2'd0:    txShift <= {txShift[30:0], 1'b0};
          2'd1:    txShift <= {txShift[29:0], 2'b00};
          default: txShift <= {txShift[27:0], 4'b0000};
        endcase
      end
      if (strb.sample) begin
        case (desc.laneSel)
          2'd0:    rxBits <= {rxBits[30:0], sioIn[1]};
          2'd1:    rxBits <= {rxBits[29:0], sioIn[1:0]};
          default: rxBits <= {rxBits[27:0], sioIn[3:0]};
        endcase
      end
    end
  end

  // Place n arrived bytes at the top of the word, first byte lowest
  always_comb begin
    alignWord = '0;
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (i < int'(desc.nBytes)) begin
        alignWord[8*(WORD_BYTES - int'(desc.nBytes) + i) +: 8] =
          rxBits[8*(int'(desc.nBytes) - 1 - i) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord  <= '0;
      rxValid <= 1'b0;
      rxOvf   <= 1'b0;
    end else begin
      if (strb.finish) begin
        rxWord  <= alignWord;
        rxValid <= 1'b1;
      end else if (strb.pop) begin
        rxValid <= 1'b0;
      end
      if (strb.clrOvf) rxOvf <= 1'b0;
      if (strb.finish && rxValid && !strb.pop) rxOvf <= 1'b1;
    end
  end

  // Lane drivers
  always_comb begin
    sioOut = {4{idleLvl}};
    sioOe  = 4'b0000;
    if (hostEn) begin
      if (!busy) begin
        sioOe = 4'b1101;
      end else begin
        case (desc.laneSel)
          2'd0: begin
            sioOe     = 4'b1101;
            sioOut[0] = desc.rdMode ? 1'b1 : txShift[31];
          end
          2'd1: begin
            sioOe       = desc.rdMode ? 4'b1100 : 4'b1111;
            sioOut[1:0] = txShift[31:30];
          end
          default: begin
            sioOe  = desc.rdMode ? 4'b0000 : 4'b1111;
            sioOut = txShift[31:28];
          end
        endcase
      end
    end
  end

  AST_RX_POP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.finish) |=> !rxValid); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rxOvf && !strb.clrOvf) |=> rxOvf); // R6
  AST_OVF_ON_UNREAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && rxValid && !strb.pop) |=> (rxOvf && rxValid)); // R6
  AST_FINISH_SETS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> rxValid); // R4

endmodule

// File: rtl/spi_lane_host.sv
module spi_lane_host
  import spi_lane_host_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sclk,
  output logic              csN,
  output logic [3:0]        sioOut,
  output logic [3:0]        sioOe,
  input  logic [3:0]        sioIn
);

  logic [31:0]      cfgReg;
  logic             hostEn;
  logic [DIV_W-1:0] divReg;
  logic [31:0]      opReg;
  xferDesc_t        desc;
  dpStrobe_t        strb;
  logic             busy;
  logic [31:0]      rxWord;
  logic             rxValid;
  logic             rxOvf;

  spi_lane_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .cfgReg   (cfgReg),
    .hostEn   (hostEn),
    .divReg   (divReg),
    .opReg    (opReg),
    .desc     (desc),
    .strb     (strb),
    .busy     (busy),
    .sclk     (sclk),
    .csN      (csN)
  );

  spi_lane_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .desc     (desc),
    .loadWord (regWdata),
    .hostEn   (hostEn),
    .idleLvl  (cfgReg[CFG_IDLE_LVL]),
    .busy     (busy),
    .sioIn    (sioIn),
    .sioOut   (sioOut),
    .sioOe    (sioOe),
    .rxWord   (rxWord),
    .rxValid  (rxValid),
    .rxOvf    (rxOvf)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(OFF_CFG)) regRdata = cfgReg;
    if (regAddr == ADDR_W'(OFF_STS)) regRdata = {27'd0, rxOvf, ~rxValid, rxValid, ~busy, ~busy};
    if (regAddr == ADDR_W'(OFF_EN))  regRdata = {31'd0, hostEn};
    if (regAddr == ADDR_W'(OFF_RXD)) regRdata = rxWord;
    if (regAddr == ADDR_W'(OFF_DIV)) regRdata = 32'(divReg);
    if (regAddr == ADDR_W'(OFF_OPC)) regRdata = opReg;
  end

endmodule

// File: tb/test_spi_lane_host.sv
module test_spi_lane_host;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sclk;
  logic        csN;
  logic [3:0]  sioOut;
  logic [3:0]  sioOe;
  logic [3:0]  sioIn = '0;

  always #10 clk = ~clk;

  spi_lane_host i_spi_lane_host (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .sclk(sclk), .csN(csN), .sioOut(sioOut), .sioOe(sioOe), .sioIn(sioIn)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Peripheral model state
  bit          mCpol = 0;
  bit          mCpha = 0;
  int          mLanes = 1;
  logic [31:0] slvStream = '0;
  logic [31:0] capStream = '0;
  int          edgeCount = 0;
  int          stepIdx = 0;
  int          cyc = 0;
  int          lastEdgeCyc = 0;
  int          gap = 0;
  logic        prevSclk = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] slvBits(input int idx);
    logic [31:0] s;
    s = (idx * mLanes >= 32) ? 32'd0 : (slvStream << (idx * mLanes));
    if (mLanes == 1) return {2'b00, s[31], 1'b0};
    if (mLanes == 2) return {2'b00, s[31:30]};
    return s[31:28];
  endfunction

  function automatic logic [3:0] mstBits();
    if (mLanes == 1) return {3'b000, sioOut[0]};
    if (mLanes == 2) return {2'b00, sioOut[1:0]};
    return sioOut;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rstN && sclk !== prevSclk) begin
      bit lead;
      lead = (sclk != mCpol);
      edgeCount++;
      gap = cyc - lastEdgeCyc;
      lastEdgeCyc = cyc;
      if (lead != mCpha) begin
        capStream = (capStream << mLanes) | 32'(mstBits());
      end else if (!(mCpha && edgeCount == 1)) begin
        stepIdx++;
        sioIn = slvBits(stepIdx);
      end
    end
    prevSclk = sclk;
  end

  task automatic monArm(input int lanes, input bit cpol, input bit cpha, input logic [31:0] slvWord);
    mLanes = lanes; mCpol = cpol; mCpha = cpha;
    for (int b = 0; b < 4; b++) slvStream[8*(3-b) +: 8] = slvWord[8*b +: 8];
    capStream = '0; edgeCount = 0; stepIdx = 0;
    sioIn = slvBits(0);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      regRead(8'h04, s);
      if (s[0]) return;
    end
  endtask

  function automatic logic [31:0] expStream(input logic [31:0] d, input int n);
    logic [31:0] e = '0;
    for (int i = 0; i < n; i++) e = (e << 8) | 32'(d[8*i +: 8]);
    return e;
  endfunction

  function automatic logic [31:0] expRx(input logic [31:0] s, input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) w[8*(4-n+i) +: 8] = s[8*i +: 8];
    return w;
  endfunction

  function automatic logic [31:0] nMask(input int n);
    return (n == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*n)) - 1);
  endfunction

  // One full transfer with wire and receive-word checks
  task automatic xfer(input string req, input int lanes, input bit cpol, input bit cpha,
                      input int n, input logic [31:0] txd, input logic [31:0] slv, input bit rd);
    logic [31:0] r;
    repeat (3) @(negedge clk);
    monArm(lanes, cpol, cpha, slv);
    regWrite(8'h14 + 8'((n % 4) * 4), txd);
    waitDone();
    check({req, " tx stream"}, capStream & nMask(n),
          rd && lanes == 1 ? nMask(n) : expStream(txd, n));
    check({req, " R9 edges"}, 32'(edgeCount), 32'(16 * n / lanes));
    regRead(8'h04, r);
    check({req, " R5 pending"}, r & 32'h1F, 32'h07);
    regRead(8'h24, r);
    check({req, " R4 rx word"}, r, expRx(slv, n));
    regRead(8'h04, r);
    check({req, " R5 popped"}, r & 32'h1F, 32'h0B);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    regRead(8'h04, r);
    check("R1 reset status", r, 32'h0000_000B);
    check("R11 reset csN", 32'(csN), 32'd1);
    check("R12 disabled oe", 32'(sioOe), 32'd0);
    check("R9 reset sclk", 32'(sclk), 32'd0);
  endtask

  task automatic t_single();
    regWrite(8'h10, 32'd1);
    regWrite(8'h28, 32'd1);
    regWrite(8'h30, 32'd0);
    regWrite(8'h00, 32'h0001_0003);
    @(negedge clk);
    check("R11 manual csN low", 32'(csN), 32'd0);
    check("R12 idle lanes high", {24'd0, sioOe, sioOut & sioOe}, 32'h0000_00DD);
    xfer("R3 R2 single 4B", 1, 0, 0, 4, 32'h4433_2211, 32'hF00F_3CA5, 0);
    check("R9 half period div1", 32'(gap), 32'd2);
    xfer("R2 R4 single 1B", 1, 0, 0, 1, 32'h0000_00C3, 32'h0000_005A, 0);
    xfer("R2 R4 single 2B", 1, 0, 0, 2, 32'h0000_81E7, 32'h0000_9966, 0);
    xfer("R2 R4 single 3B", 1, 0, 0, 3, 32'h00AB_CDEF, 32'h0012_3456, 0);
    regWrite(8'h00, 32'h0000_0002);
    @(negedge clk);
    check("R11 manual csN high", 32'(csN), 32'd1);
    check("R12 idle lanes low", {24'd0, sioOe, sioOut & sioOe}, 32'h0000_00D0);
  endtask

  task automatic t_lanes();
    regWrite(8'h30, 32'h0000_0040);
    xfer("R7 dual write", 2, 0, 0, 4, 32'hDEAD_BEEF, 32'h1357_9BDF, 0);
    regWrite(8'h30, 32'h0000_0080);
    xfer("R7 quad write", 4, 0, 0, 3, 32'h0076_5432, 32'h00A1_B2C3, 0);
    regWrite(8'h30, 32'h0000_00C0);
    xfer("R7 code3 as quad", 4, 0, 0, 2, 32'h0000_F00D, 32'h0000_6E5D, 0);
  endtask

  task automatic t_read_flag();
    logic [31:0] r;
    regWrite(8'h30, 32'h0080_0000);
    xfer("R8 single read ones", 1, 0, 0, 2, 32'h0000_0000, 32'h0000_C0DE, 1);
    regWrite(8'h30, 32'h0080_0040);
    monArm(2, 0, 0, 32'h0000_7EA5);
    regWrite(8'h18, 32'h0);
    repeat (3) @(negedge clk);
    check("R8 dual read oe", 32'(sioOe), 32'h0000_000C);
    waitDone();
    regRead(8'h24, r);
    check("R8 dual read rx", r, expRx(32'h0000_00A5, 1));
    regWrite(8'h30, 32'h0080_0080);
    monArm(4, 0, 0, 32'h0000_3C96);
    regWrite(8'h1C, 32'h0);
    repeat (2) @(negedge clk);
    check("R8 quad read oe", 32'(sioOe), 32'h0000_0000);
    waitDone();
    regRead(8'h24, r);
    check("R8 quad read rx", r, expRx(32'h0000_3C96, 2));
    regWrite(8'h30, 32'h0);
  endtask

  task automatic t_modes();
    regWrite(8'h00, 32'h0008_0003);
    repeat (2) @(negedge clk);
    check("R9 idle cpol1", 32'(sclk), 32'd1);
    xfer("R10 cpol1 cpha0", 1, 1, 0, 2, 32'h0000_A55A, 32'h0000_0FF0, 0);
    regWrite(8'h00, 32'h0010_0003);
    repeat (2) @(negedge clk);
    check("R9 idle cpol0", 32'(sclk), 32'd0);
    xfer("R10 cpol0 cpha1", 1, 0, 1, 2, 32'h0000_3CC3, 32'h0000_E718, 0);
    regWrite(8'h00, 32'h0018_0003);
    regWrite(8'h30, 32'h0000_0080);
    xfer("R10 cpol1 cpha1 quad", 4, 1, 1, 4, 32'h8421_1248, 32'h7BDE_EDB7, 0);
    regWrite(8'h30, 32'h0);
    regWrite(8'h00, 32'h0000_0003);
    regWrite(8'h28, 32'd3);
    xfer("R9 div3", 1, 0, 0, 1, 32'h0000_0096, 32'h0000_0069, 0);
    check("R9 half period div3", 32'(gap), 32'd4);
    regWrite(8'h28, 32'd0);
  endtask

  task automatic t_overflow();
    logic [31:0] r;
    repeat (2) @(negedge clk);
    monArm(1, 0, 0, 32'h0000_0011);
    regWrite(8'h18, 32'h0000_0001);
    waitDone();
    monArm(1, 0, 0, 32'h0000_0022);
    regWrite(8'h18, 32'h0000_0002);
    waitDone();
    regRead(8'h04, r);
    check("R6 overflow set", r & 32'h1F, 32'h17);
    regRead(8'h24, r);
    check("R6 newest kept", r, 32'h2200_0000);
    regRead(8'h04, r);
    check("R6 overflow sticky", r & 32'h1F, 32'h1B);
    regWrite(8'h04, 32'h0000_0010);
    regRead(8'h04, r);
    check("R6 overflow cleared", r & 32'h1F, 32'h0B);
  endtask

  task automatic t_ignored();
    logic [31:0] r;
    repeat (2) @(negedge clk);
    monArm(1, 0, 0, 32'h0000_00B4);
    regWrite(8'h18, 32'h0000_004B);
    regWrite(8'h14, 32'hFFFF_FFFF);
    waitDone();
    check("R2 busy write ignored edges", 32'(edgeCount), 32'd16);
    regRead(8'h24, r);
    check("R2 busy write ignored rx", r, 32'hB400_0000);
    regWrite(8'h10, 32'd0);
    monArm(1, 0, 0, 32'h0);
    regWrite(8'h14, 32'h1234_5678);
    repeat (40) @(negedge clk);
    check("R2 disabled no edges", 32'(edgeCount), 32'd0);
    regRead(8'h04, r);
    check("R2 disabled status", r, 32'h0000_000B);
    check("R11 disabled csN", 32'(csN), 32'd1);
    check("R12 disabled oe", 32'(sioOe), 32'd0);
    regWrite(8'h10, 32'd1);
  endtask

  task automatic t_auto_cs();
    regWrite(8'h00, 32'h0000_0000);
    @(negedge clk);
    check("R11 auto idle csN", 32'(csN), 32'd1);
    monArm(1, 0, 0, 32'h0000_0033);
    regWrite(8'h18, 32'h0000_00CC);
    repeat (2) @(negedge clk);
    check("R11 auto active csN", 32'(csN), 32'd0);
    waitDone();
    check("R11 auto done csN", 32'(csN), 32'd1);
    check("R11 auto capture", capStream & 32'hFF, 32'h0000_00CC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_lanes();
    t_read_flag();
    t_modes();
    t_overflow();
    t_ignored();
    t_auto_cs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule